// File: doc/BRIEF.md
# Serial EEPROM Target Engine

This block is the protocol side of a two-wire serial EEPROM. It watches the clock and data lines and picks out start and stop conditions. It takes in a select byte and compares it with a chip-enable strap, then takes two address bytes. It answers byte writes, page writes, random reads, current-address reads and sequential reads. The storage behind it is a byte-wide main array and a separate 256-byte identification page. Both are modelled as simple synchronous RAMs.

The block runs on a fast system clock and oversamples both bus lines. Its only bus output is a registered open-drain pull-down request. Written bytes are gathered in a 256-entry page latch. They are copied into storage during an internal write cycle whose length is a parameter. During that cycle the target ignores the bus completely. A write-protect strap blocks all data writes. A lock command freezes the identification page until the next reset.

The main array depth is `2**MEM_AW` bytes. The 18-bit byte address is used modulo that depth.

Top module: `eep_i2c_target`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. Outside a write cycle, a start begins a new select byte at any point, including a repeated start in the middle of a transfer.
- R2: Bits are taken on SCL rising edges, MSB first. The target pulls SDA low in the ninth clock to acknowledge. It only starts a pull-down after detecting an SCL falling edge, and it releases SDA after reset.
- R3: The select byte is decoded as follows. Bits 7..4 are 1010 for the main array and 1011 for the identification page. Bit 3 must equal `chip_en`. Bits 2..1 are address bits 17..16 for the array. Bit 0 is 1 for a read and 0 for a write. Any other select byte gets no acknowledge, and the target then ignores the bus until the next start.
- R4: A write select byte is followed by a high and then a low address byte, and each is acknowledged. The data bytes are acknowledged and stored at address {select bits 2..1, high byte, low byte}.
- R5: In a page write, only the low 8 address bits advance. Bytes that pass offset 255 wrap to offset 0 of the same 256-byte page.
- R6: While `wr_protect` is high, the select and address bytes are acknowledged, but every data byte is refused. No storage changes and no write cycle starts.
- R7: A write cycle starts only when a stop comes right after an accepted data byte's acknowledge slot. A stop anywhere else leaves storage unchanged and the target idle.
- R8: For WR_CYCLES clocks (at least 258) after a write cycle starts, the target drives nothing and acknowledges nothing, not even its own select byte. Afterwards it answers again.
- R9: A read returns the byte at the address pointer. The pointer then advances through the full 18 bits while the controller acknowledges, and a refused byte ends the read. After a write cycle the pointer holds the byte after the last one written, which is what a current-address read returns.
- R10: With select type 1011, a high address byte whose bit 2 is 0 writes and reads the identification page at the low address byte.
- R11: With select type 1011 and high address bit 2 set, a data byte with bit 1 set locks the identification page once the write cycle ends. After that, data bytes to the page are refused and its contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| chip_en | input | 1 | Strap compared with select bit 3 |
| wr_protect | input | 1 | High blocks every data write |
| sda_low | output | 1 | Registered request to pull SDA low |

## Verification
Two functions can fall on the same bus event. One is a stop that ends a transfer. The other is the write-cycle trigger, which is tied to the slot just after a data acknowledge. The bench provokes both orders. It sends a stop right after an accepted data byte, which must start a busy period. It also sends a stop right after the low address byte and a stop after refused data bytes under write protection. The busy period is judged by whether the very next select byte is acknowledged: it is refused while busy and acknowledged at once otherwise. The contents are then read back to confirm that nothing was written.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  localparam logic [3:0] KIND_ARRAY = 4'b1010;
  localparam logic [3:0] KIND_IDPG  = 4'b1011;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, scl_s, scl_d;
  logic sda_m, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

  assert_cond_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(start_ev && stop_ev) && !((start_ev || stop_ev) && (scl_rise || scl_fall)));
endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
  import eep_pkg::*;
#(
  parameter int MEM_AW    = 11,
  parameter int WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic chip_en,
  input  logic wr_protect,
  output logic sda_low
);
  localparam int PG_AW    = 8;
  localparam int PG_SZ    = 1 << PG_AW;
  localparam int BUSY_LEN = (WR_CYCLES > PG_SZ + 2) ? WR_CYCLES : PG_SZ + 2;
  localparam int BCNT_W   = $clog2(BUSY_LEN + 1);

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eep_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_state_e        state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txreg;
  logic [17:0]       ptr;
  logic              sel_id, is_rd, lock_mode, lock_pend, have_data, m_ack;
  logic              id_locked, busy, cm_id, cm_lock;
  logic [BCNT_W-1:0] bcnt;
  logic [PG_AW:0]    walk_idx;
  logic [PG_SZ-1:0]  valid;
  logic              wr_en_q;
  logic [PG_AW-1:0]  wr_idx_q;
  logic [7:0]        lat_q, arr_q, id_q, rd_byte;

  // Bus event qualifiers
  logic bus_live, byte_end, slot_end, dev_match, data_ok, lat_we;
  always_comb begin
    bus_live  = !busy && !stop_ev && !start_ev;
    byte_end  = bus_live && scl_fall && (bitcnt == 4'd8);
    slot_end  = bus_live && scl_fall && (bitcnt == 4'd9);
    dev_match = ((shreg[7:4] == KIND_ARRAY) || (shreg[7:4] == KIND_IDPG)) &&
                (shreg[3] == chip_en);
    data_ok   = !wr_protect && !(sel_id && id_locked);
    lat_we    = byte_end && (state == ST_WDATA) && data_ok && !lock_mode;
    rd_byte   = sel_id ? id_q : arr_q;
  end

  // Storage: page latch, main array, identification page
  eep_ram #(.AW(PG_AW), .DW(8)) u_latch (
    .clk(clk), .we(lat_we), .waddr(ptr[PG_AW-1:0]), .wdata(shreg),
    .raddr(walk_idx[PG_AW-1:0]), .rdata(lat_q)
  );
  eep_ram #(.AW(MEM_AW), .DW(8)) u_array (
    .clk(clk), .we(wr_en_q && !cm_id), .waddr(MEM_AW'({ptr[17:PG_AW], wr_idx_q})),
    .wdata(lat_q), .raddr(MEM_AW'(ptr)), .rdata(arr_q)
  );
  eep_ram #(.AW(PG_AW), .DW(8)) u_idpage (
    .clk(clk), .we(wr_en_q && cm_id), .waddr(wr_idx_q), .wdata(lat_q),
    .raddr(ptr[PG_AW-1:0]), .rdata(id_q)
  );

  // Commit walker: one latch entry per clock during the busy period
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_q  <= 1'b0;
      wr_idx_q <= '0;
    end else begin
      wr_en_q  <= busy && !walk_idx[PG_AW] && valid[walk_idx[PG_AW-1:0]];
      wr_idx_q <= walk_idx[PG_AW-1:0];
    end
  end

  // Protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0; txreg <= '0; ptr <= '0;
      sel_id <= 1'b0; is_rd <= 1'b0; lock_mode <= 1'b0; lock_pend <= 1'b0;
      have_data <= 1'b0; m_ack <= 1'b0; id_locked <= 1'b0; busy <= 1'b0;
      cm_id <= 1'b0; cm_lock <= 1'b0; bcnt <= '0; walk_idx <= '0;
      valid <= '0; sda_low <= 1'b0;
    end else if (busy) begin
      sda_low <= 1'b0;
      state   <= ST_IDLE;
      bcnt    <= bcnt + 1'b1;
      if (!walk_idx[PG_AW]) walk_idx <= walk_idx + 1'b1;
      if (bcnt == BCNT_W'(BUSY_LEN - 1)) begin
        busy      <= 1'b0;
        valid     <= '0;
        have_data <= 1'b0;
        if (cm_lock) id_locked <= 1'b1;
      end
    end else if (stop_ev) begin
      sda_low <= 1'b0;
      state   <= ST_IDLE;
      if (state == ST_WDATA && bitcnt == 4'd1 && have_data) begin
        busy     <= 1'b1;
        bcnt     <= '0;
        walk_idx <= '0;
        cm_id    <= sel_id;
        cm_lock  <= lock_mode && lock_pend;
      end
    end else if (start_ev) begin
      state   <= ST_DEVSEL;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (scl_rise) begin
      if (bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (bitcnt == 4'd9) begin
        m_ack <= ~sda_s;
      end
    end else if (byte_end) begin
      bitcnt <= 4'd9;
      unique case (state)
        ST_DEVSEL: begin
          if (dev_match) begin
            sda_low <= 1'b1;
            sel_id  <= shreg[4];
            is_rd   <= shreg[0];
            if (!shreg[4]) ptr[17:16] <= shreg[2:1];
            if (!shreg[0]) begin
              valid <= '0; have_data <= 1'b0; lock_pend <= 1'b0; lock_mode <= 1'b0;
            end
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ADDR_HI: begin
          sda_low   <= 1'b1;
          lock_mode <= sel_id && shreg[2];
          if (!sel_id) ptr[15:8] <= shreg;
        end
        ST_ADDR_LO: begin
          sda_low  <= 1'b1;
          ptr[7:0] <= shreg;
        end
        ST_WDATA: begin
          if (data_ok) begin
            sda_low   <= 1'b1;
            have_data <= 1'b1;
            if (lock_mode) begin
              lock_pend <= lock_pend | shreg[1];
            end else begin
              valid[ptr[PG_AW-1:0]] <= 1'b1;
              ptr[7:0] <= ptr[7:0] + 8'd1;
            end
          end
        end
        ST_RDATA: begin
          sda_low <= 1'b0;
          if (sel_id) ptr[7:0] <= ptr[7:0] + 8'd1;
          else        ptr      <= ptr + 18'd1;
        end
        default: ;
      endcase
    end else if (slot_end) begin
      bitcnt  <= '0;
      sda_low <= 1'b0;
      unique case (state)
        ST_DEVSEL: begin
          if (is_rd) begin
            state   <= ST_RDATA;
            txreg   <= rd_byte;
            sda_low <= ~rd_byte[7];
          end else begin
            state <= ST_ADDR_HI;
          end
        end
        ST_ADDR_HI: state <= ST_ADDR_LO;
        ST_ADDR_LO: state <= ST_WDATA;
        ST_RDATA: begin
          if (m_ack) begin
            txreg   <= rd_byte;
            sda_low <= ~rd_byte[7];
          end else begin
            state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end else if (bus_live && scl_fall && state == ST_RDATA &&
                 bitcnt != 4'd0 && bitcnt < 4'd8) begin
      sda_low <= ~txreg[6];
      txreg   <= {txreg[6:0], 1'b0};
    end
  end

  assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_low);
  assert_drive_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> $past(scl_fall));
  assert_cycle_after_stop_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_ev));
  assert_commit_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> busy);
  assert_protect_no_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_protect && $past(wr_protect) && $rose(busy)) |-> $past(have_data));
endmodule

// File: tb/eep_i2c_target_tb.sv
module eep_i2c_target_tb;
  localparam int MEM_AW = 11;
  localparam int WRC    = 300;
  localparam int QTR    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic chip_en = 1'b1, wr_protect = 1'b0;
  logic sda_low;
  wire  sda_bus = sda_m & ~sda_low;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eep_i2c_target #(.MEM_AW(MEM_AW), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .chip_en(chip_en), .wr_protect(wr_protect), .sda_low(sda_low)
  );

  // {address, data} pairs for single-byte writes followed by read-back
  localparam logic [25:0] VEC [5] = '{
    {18'h00000, 8'h3C}, {18'h00102, 8'h5A}, {18'h107FF, 8'hC3},
    {18'h00040, 8'h96}, {18'h20301, 8'h0F}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; quarter(); scl_m = 1'b1; quarter();
    sda_m = 1'b0; quarter(); scl_m = 1'b0; quarter();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; quarter(); scl_m = 1'b1; quarter();
    sda_m = 1'b1; quarter(); quarter();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; quarter(); scl_m = 1'b1; quarter(); quarter();
      scl_m = 1'b0; quarter();
    end
    sda_m = 1'b1; quarter(); scl_m = 1'b1; quarter();
    ack = (sda_bus == 1'b0);
    quarter(); scl_m = 1'b0; quarter();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      quarter(); scl_m = 1'b1; quarter();
      b[i] = sda_bus;
      quarter(); scl_m = 1'b0; quarter();
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    quarter(); scl_m = 1'b1; quarter(); quarter(); scl_m = 1'b0; quarter();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dsel(input logic [17:0] a, input logic rd);
    return {4'b1010, 1'b1, a[17:16], rd};
  endfunction

  task automatic wr_bytes(input logic [7:0] ds, input logic [7:0] hi, input logic [7:0] lo,
                          input int n, input logic [31:0] d,
                          output logic [2:0] hdr_ack, output logic [3:0] dat_ack);
    logic a;
    bus_start();
    send_byte(ds, a); hdr_ack[2] = a;
    send_byte(hi, a); hdr_ack[1] = a;
    send_byte(lo, a); hdr_ack[0] = a;
    dat_ack = '0;
    for (int k = 0; k < n; k++) begin
      send_byte(d[31-8*k -: 8], a);
      dat_ack[k] = a;
    end
    bus_stop();
  endtask

  task automatic rd_bytes(input logic [7:0] dw, input logic [7:0] hi, input logic [7:0] lo,
                          input logic [7:0] dr, input int n, output logic [31:0] q);
    logic a;
    logic [7:0] b;
    q = '0;
    bus_start();
    send_byte(dw, a); send_byte(hi, a); send_byte(lo, a);
    bus_start();
    send_byte(dr, a);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      q[31-8*k -: 8] = b;
    end
    bus_stop();
  endtask

  task automatic poll(input logic [7:0] ds, output logic ack);
    bus_start(); send_byte(ds, ack); bus_stop();
  endtask

  task automatic wait_cycle();
    repeat (WRC + 40) @(negedge clk);
  endtask

  initial begin
    logic [2:0] h;
    logic [3:0] da;
    logic [31:0] q;
    logic a;
    logic [7:0] b;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(sda_low == 1'b0, "R2", "released after reset", sda_low, 0);

    // R4 R9 R1: vector table of byte writes and random reads
    for (int i = 0; i < 5; i++) begin
      wr_bytes(dsel(VEC[i][25:8], 1'b0), VEC[i][15:8], VEC[i][7:0] == 8'h00 ? VEC[i][15:8] : VEC[i][15:8],
               0, 32'h0, h, da);
      // the call above only sets the pointer; now the real byte write
      wr_bytes(dsel(VEC[i][25:8], 1'b0), VEC[i][23:16], VEC[i][15:8], 1,
               {VEC[i][7:0], 24'h0}, h, da);
      check(h == 3'b111 && da[0], "R4", "write acks", {h, da[0]}, 4'hF);
      wait_cycle();
      rd_bytes(dsel(VEC[i][25:8], 1'b0), VEC[i][23:16], VEC[i][15:8],
               dsel(VEC[i][25:8], 1'b1), 1, q);
      check(q[31:24] == VEC[i][7:0], "R1", "random read after repeated start",
            q[31:24], VEC[i][7:0]);
    end

    // R5: page write wrapping within page 0x1xx
    wr_bytes(dsel(18'h001FE, 1'b0), 8'h01, 8'hFE, 4, 32'hAABBCCDD, h, da);
    check(da == 4'hF, "R5", "page data acks", da, 4'hF);
    wait_cycle();
    // R9: current-address read returns byte after last written (0x102)
    bus_start(); send_byte(dsel(18'h0, 1'b1), a); recv_byte(1'b0, b); bus_stop();
    check(b == 8'h5A, "R9", "current address read", b, 8'h5A);
    rd_bytes(dsel(18'h0, 1'b0), 8'h01, 8'h00, dsel(18'h0, 1'b1), 3, q);
    check(q[31:8] == 24'hCCDD5A, "R5", "wrapped bytes at page start", q[31:8], 24'hCCDD5A);
    rd_bytes(dsel(18'h0, 1'b0), 8'h01, 8'hFE, dsel(18'h0, 1'b1), 2, q);
    check(q[31:16] == 16'hAABB, "R9", "sequential read", q[31:16], 16'hAABB);

    // R6: write protect refuses data, no write cycle
    wr_protect = 1'b1;
    wr_bytes(dsel(18'h0, 1'b0), 8'h01, 8'hFE, 1, 32'h11000000, h, da);
    check(h == 3'b111, "R6", "header acked under protect", h, 7);
    check(da[0] == 1'b0, "R6", "data refused under protect", da[0], 0);
    poll(dsel(18'h0, 1'b0), a);
    check(a == 1'b1, "R6", "no busy after protected write", a, 1);
    wr_protect = 1'b0;

    // R7: stop right after address bytes starts no cycle
    bus_start(); send_byte(dsel(18'h0, 1'b0), a); send_byte(8'h01, a); send_byte(8'hFE, a);
    bus_stop();
    poll(dsel(18'h0, 1'b0), a);
    check(a == 1'b1, "R7", "no cycle after address-only stop", a, 1);
    rd_bytes(dsel(18'h0, 1'b0), 8'h01, 8'hFE, dsel(18'h0, 1'b1), 1, q);
    check(q[31:24] == 8'hAA, "R7", "contents unchanged", q[31:24], 8'hAA);

    // R8: busy ignores own select byte, then answers
    wr_bytes(dsel(18'h0, 1'b0), 8'h00, 8'h40, 1, 32'h69000000, h, da);
    poll(dsel(18'h0, 1'b0), a);
    check(a == 1'b0, "R8", "select refused while busy", a, 0);
    wait_cycle();
    poll(dsel(18'h0, 1'b0), a);
    check(a == 1'b1, "R8", "select acked after cycle", a, 1);
    rd_bytes(dsel(18'h0, 1'b0), 8'h00, 8'h40, dsel(18'h0, 1'b1), 1, q);
    check(q[31:24] == 8'h69, "R8", "value after busy", q[31:24], 8'h69);

    // R3: select mismatches
    poll(8'hA0, a);
    check(a == 1'b0, "R3", "chip enable mismatch refused", a, 0);
    bus_start(); send_byte(8'hC8, a); send_byte(8'h00, b[0]); bus_stop();
    check(a == 1'b0 && b[0] == 1'b0, "R3", "wrong kind and follow-up ignored", {a, b[0]}, 0);

    // R10: identification page write and read
    wr_bytes(8'hB8, 8'h00, 8'h10, 1, 32'h77000000, h, da);
    check(da[0] == 1'b1, "R10", "id data acked", da[0], 1);
    wait_cycle();
    rd_bytes(8'hB8, 8'h00, 8'h10, 8'hB9, 1, q);
    check(q[31:24] == 8'h77, "R10", "id read back", q[31:24], 8'h77);

    // R11: lock, then refused and unchanged
    wr_bytes(8'hB8, 8'h04, 8'h00, 1, 32'h02000000, h, da);
    check(da[0] == 1'b1, "R11", "lock command acked", da[0], 1);
    wait_cycle();
    wr_bytes(8'hB8, 8'h00, 8'h10, 1, 32'h55000000, h, da);
    check(da[0] == 1'b0, "R11", "id data refused when locked", da[0], 0);
    rd_bytes(8'hB8, 8'h00, 8'h10, 8'hB9, 1, q);
    check(q[31:24] == 8'h77, "R11", "id unchanged when locked", q[31:24], 8'h77);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule